// File: doc/BRIEF.md
# Match-Interrupt Operating-System Timer

This block is a word-wide system timer with a single compare channel. Software writes a target value into a compare register. The block then measures the gap between its stored counter and that target, wrapping around if it has to, and loads the gap into a one-shot down-counter. The down-counter steps once for every clock on which the tick-enable input is high. That input represents the 50 MHz timebase. When the down-counter runs out, the stored counter takes the target value. If alarms are enabled, a sticky status bit is set, and that bit drives a level interrupt.

The visible counter is not a free-running register. Each read works it out as the target minus the ticks that remain. Software clears the status bit by writing zero to it. Any other value written there is rejected, and the block reports the rejection on an error pulse. The register port has one strobe for reads and one for writes. All accesses are full words, and read data comes back registered.

Top module: `ost_match_timer`

## Requirements
- R1: The byte offsets are fixed: compare at 0x00 (write only, reads return 0), counter at 0x10 (read only), status at 0x14 (bit 0 is the flag, other bits read 0) and alarm enable at 0x1c (full word, read/write). A read strobe captures the selected value into bus_rdata at the clock edge, and bus_rdata holds that value until the next read.
- R2: A compare write of value V, with stored counter C, loads the countdown with V−C when V>C. Otherwise it loads V+(all-ones−C) modulo 2^DW. The countdown then starts.
- R3: A counter read returns the compare value minus the remaining countdown, modulo 2^DW.
- R4: While the countdown is running, every clock with tick_en high lowers it by one. A compare write in the same cycle takes precedence, and that tick is dropped.
- R5: The countdown expires on the tick it receives while its value is 1 or less. At expiry the stored counter becomes the compare value, the remaining count becomes 0 and the countdown stops. Later ticks change nothing until the next compare write.
- R6: At expiry the status bit is set to 1 if the enable register, as it stood before that edge, is nonzero. If it is zero, the status bit is left unchanged.
- R7: irq equals the status bit on every cycle.
- R8: Writing 0 to status clears it. Writing a nonzero value leaves it unchanged and raises bad_wr for exactly the following cycle.
- R9: If an expiry that sets status falls in the same cycle as a status clear, status ends at 1.
- R10: After reset, compare, counter, countdown, status and enable are all 0, and irq, bad_wr and bus_rdata are 0.
- R11: Reads from any other offset return 0. Writes to any other offset, and writes to the counter offset, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; one countdown step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Level interrupt, equal to the status bit |
| bad_wr | output | 1 | One-cycle pulse after a nonzero write to status |

## Verification
The bench builds the block with its defaults, DW = 32 and AW = 5. Because of this, the all-ones wrap distance is the literal 32-bit boundary. Compare writes below or equal to the stored counter load distances near 2^32 at once, so the wrap arithmetic is checked without spending cycles on ticks. The five-bit offset also makes room for the unused holes at 0x04, 0x08 and 0x18, so the ignore rule is exercised alongside the mapped registers.

// File: rtl/ost_pkg.sv
package ost_pkg;

    localparam int unsigned OFS_CMP    = 'h00;
    localparam int unsigned OFS_COUNT  = 'h10;
    localparam int unsigned OFS_STATUS = 'h14;
    localparam int unsigned OFS_ENABLE = 'h1c;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMP,
        SEL_COUNT,
        SEL_STATUS,
        SEL_ENABLE
    } ost_sel_e;

endpackage

// File: rtl/ost_decode.sv
module ost_decode
    import ost_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] addr,
    output ost_sel_e      sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == AW'(OFS_CMP))         sel = SEL_CMP;
        else if (addr == AW'(OFS_COUNT))  sel = SEL_COUNT;
        else if (addr == AW'(OFS_STATUS)) sel = SEL_STATUS;
        else if (addr == AW'(OFS_ENABLE)) sel = SEL_ENABLE;
    end

endmodule

// File: rtl/ost_distance.sv
module ost_distance #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] target,
    input  logic [DW-1:0] origin,
    output logic [DW-1:0] span
);

    localparam logic [DW-1:0] ALL_ONES = '1;

    // Wrap-aware gap: straight difference when ahead, else go around the top.
    always_comb begin
        if (target > origin) span = target - origin;
        else                 span = target + (ALL_ONES - origin);
    end

endmodule

// File: rtl/ost_countdown.sv
module ost_countdown #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          tick,
    output logic [DW-1:0] remain,
    output logic          fire
);

    typedef struct packed {
        logic [DW-1:0] remain;
        logic          run;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (load) begin
            st_d.remain = load_val;
            st_d.run    = 1'b1;
        end else if (st_q.run && tick) begin
            if (st_q.remain <= DW'(1)) begin
                fire        = 1'b1;
                st_d.remain = '0;
                st_d.run    = 1'b0;
            end else begin
                st_d.remain = st_q.remain - DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign remain = st_q.remain;

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick && !load && st_q.remain > DW'(1))
        |=> (st_q.remain == $past(st_q.remain) - DW'(1)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !load) |=> $stable(st_q.remain));

    // R5
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.remain == '0 && !st_q.run));

endmodule

// File: rtl/ost_readmux.sv
module ost_readmux
    import ost_pkg::*;
#(
    parameter int DW = 32
) (
    input  ost_sel_e      sel,
    input  logic [DW-1:0] count_val,
    input  logic          status,
    input  logic [DW-1:0] enable,
    output logic [DW-1:0] value
);

    always_comb begin
        unique case (sel)
            SEL_COUNT:  value = count_val;
            SEL_STATUS: value = DW'(status);
            SEL_ENABLE: value = enable;
            default:    value = '0;
        endcase
    end

endmodule

// File: rtl/ost_match_timer.sv
module ost_match_timer
    import ost_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          bad_wr
);

    typedef struct packed {
        logic [DW-1:0] cmp;
        logic [DW-1:0] cnt;
        logic [DW-1:0] ien;
        logic [DW-1:0] rdata;
        logic          stat;
        logic          bad;
    } regs_t;

    regs_t st_d, st_q;

    ost_sel_e      sel;
    logic          load;
    logic [DW-1:0] span;
    logic [DW-1:0] remain;
    logic          fire;
    logic [DW-1:0] count_val;
    logic [DW-1:0] rd_value;

    ost_decode #(.AW(AW)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign load = bus_wr && (sel == SEL_CMP);

    ost_distance #(.DW(DW)) u_distance (
        .target (bus_wdata),
        .origin (st_q.cnt),
        .span   (span)
    );

    ost_countdown #(.DW(DW)) u_countdown (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (span),
        .tick     (tick_en),
        .remain   (remain),
        .fire     (fire)
    );

    assign count_val = st_q.cmp - remain;

    ost_readmux #(.DW(DW)) u_readmux (
        .sel       (sel),
        .count_val (count_val),
        .status    (st_q.stat),
        .enable    (st_q.ien),
        .value     (rd_value)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (load) st_d.cmp = bus_wdata;
        if (fire) st_d.cnt = st_q.cmp;
        if (bus_wr && sel == SEL_ENABLE) st_d.ien = bus_wdata;
        if (bus_wr && sel == SEL_STATUS) begin
            if (bus_wdata == '0) st_d.stat = 1'b0;
            else                 st_d.bad  = 1'b1;
        end
        // Expiry after the clear so a same-cycle event is kept.
        if (fire && st_q.ien != '0) st_d.stat = 1'b1;
        if (bus_rd) st_d.rdata = rd_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = st_q.stat;
    assign bad_wr    = st_q.bad;

    // R5
    cnt_takes_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.cnt == $past(st_q.cmp)));

    // R6
    alarm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.ien != '0) |=> irq);

    // R6
    alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.ien == '0 && !irq) |=> !irq);

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_STATUS && bus_wdata == '0 && !fire) |=> !irq);

    // R8
    status_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_STATUS && bus_wdata != '0 && !fire)
        |=> (bad_wr && $stable(irq)));

    // R11
    hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_NONE || sel == SEL_COUNT) && !fire)
        |=> ($stable(irq) && $stable(st_q.ien) && $stable(st_q.cmp)));

endmodule

// File: tb/tb_ost_match_timer.sv
module tb_ost_match_timer;

    localparam logic [4:0] A_CMP = 5'h00;
    localparam logic [4:0] A_CNT = 5'h10;
    localparam logic [4:0] A_STS = 5'h14;
    localparam logic [4:0] A_IEN = 5'h1c;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        bad_wr;

    ost_match_timer #(.DW(32), .AW(5)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .bad_wr(bad_wr)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "";
    logic        rd_seen = 1'b0;

    // Reference state, built from the requirements
    logic [31:0] m_cmp = 0, m_cnt = 0, m_rem = 0, m_ien = 0;
    bit          m_run = 0, m_stat = 0, m_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare each read result against the scoreboard
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("read with empty scoreboard", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic cyc(input bit wr, input logic [4:0] a, input logic [31:0] d,
                       input bit rd, input bit tk);
        logic [31:0] rv;
        logic [31:0] ien_old;
        bit fired;
        if (rd) begin
            case (a)
                A_CNT:   rv = m_cmp - m_rem;
                A_STS:   rv = {31'b0, m_stat};
                A_IEN:   rv = m_ien;
                default: rv = 32'h0;
            endcase
            exp_q.push_back(rv);
            tag_q.push_back(cur_tag);
        end
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; tick_en = 1'b0;
        ien_old = m_ien;
        fired = 0;
        if (wr && a == A_CMP) begin
            m_rem = (d > m_cnt) ? d - m_cnt : d + (32'hFFFF_FFFF - m_cnt);
            m_cmp = d;
            m_run = 1;
        end else if (tk && m_run) begin
            if (m_rem <= 1) begin
                fired = 1; m_rem = 0; m_run = 0; m_cnt = m_cmp;
            end else begin
                m_rem = m_rem - 1;
            end
        end
        m_bad = 0;
        if (wr && a == A_STS) begin
            if (d == 0) m_stat = 0;
            else        m_bad = 1;
        end
        if (fired && ien_old != 0) m_stat = 1;
        if (wr && a == A_IEN) m_ien = d;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 0);
    endtask

    task automatic rd(input logic [4:0] a);
        cyc(0, a, 0, 1, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
    endtask

    task automatic pins(input string tag);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_stat});
        check({tag, " bad_wr"}, {31'b0, bad_wr}, {31'b0, m_bad});
    endtask

    initial begin
        #2_000_000;
        check("watchdog expired", 32'h1, 32'h0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 rdata", bus_rdata, 32'h0);
        pins("R10");
        cur_tag = "R10 counter"; rd(A_CNT);
        cur_tag = "R10 status";  rd(A_STS);
        cur_tag = "R10 enable";  rd(A_IEN);

        // R1 enable full word, compare reads 0
        wr(A_IEN, 32'hA5A5_0001);
        cur_tag = "R1 enable readback"; rd(A_IEN);
        wr(A_CMP, 32'd10);
        cur_tag = "R1 compare reads zero"; rd(A_CMP);

        // R2/R3/R4 countdown from 0 to 10
        cur_tag = "R3 counter after load"; rd(A_CNT);
        ticks(4);
        cur_tag = "R4 counter after 4 ticks"; rd(A_CNT);
        ticks(5);
        cur_tag = "R4 counter after 9 ticks"; rd(A_CNT);
        pins("R6 before expiry");
        ticks(1);
        pins("R7 at expiry");
        cur_tag = "R6 status set"; rd(A_STS);
        cur_tag = "R5 counter equals compare"; rd(A_CNT);
        ticks(3);
        cur_tag = "R5 one-shot hold"; rd(A_CNT);

        // R8 status write rules
        wr(A_STS, 32'd5);
        pins("R8 reject");
        cyc(0, 0, 0, 0, 0);
        pins("R8 pulse ends");
        cur_tag = "R8 status kept"; rd(A_STS);
        wr(A_STS, 32'd0);
        pins("R8 clear");
        cur_tag = "R8 status cleared"; rd(A_STS);

        // R2 wrap below stored counter 10
        wr(A_CMP, 32'd4);
        cur_tag = "R2 wrap distance"; rd(A_CNT);
        wr(A_IEN, 32'd0);
        wr(A_CMP, 32'd12);
        ticks(2);
        pins("R6 disabled expiry");
        cur_tag = "R6 status untouched"; rd(A_STS);
        cur_tag = "R5 counter 12"; rd(A_CNT);

        // R2 equal case
        wr(A_CMP, 32'd12);
        cur_tag = "R2 equal distance"; rd(A_CNT);

        // R11 holes and read-only counter
        wr(5'h04, 32'hDEAD_BEEF);
        wr(A_CNT, 32'h1234_5678);
        wr(5'h18, 32'hFFFF_FFFF);
        pins("R11 after hole writes");
        cur_tag = "R11 hole 04"; rd(5'h04);
        cur_tag = "R11 hole 08"; rd(5'h08);
        cur_tag = "R11 counter unchanged"; rd(A_CNT);
        cur_tag = "R11 enable unchanged"; rd(A_IEN);

        // R4 compare write beats a same-cycle tick
        cyc(1, A_CMP, 32'd20, 0, 1);
        cur_tag = "R4 tick dropped on load"; rd(A_CNT);

        // R9 expiry and clear together
        wr(A_IEN, 32'd1);
        wr(A_CMP, 32'd13);
        cyc(1, A_STS, 32'd0, 0, 1);
        pins("R9 set wins");
        cur_tag = "R9 status"; rd(A_STS);

        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        if (exp_q.size() != 0) check("scoreboard not drained", exp_q.size(), 0);
        report();
        $finish;
    end

endmodule